// File: doc/BRIEF.md
# SPI Port Supervisor

This block is the processor-facing side of an SPI port that can act as either master or slave. A small byte-wide bus with two address bits reaches four registers: configuration, flags, transfer data and slave-select pattern. A write to the data register loads the transmit byte for the shift engine. When the port is an enabled master, the same write also starts a transfer and drives the stored select pattern onto the active-low select pins. The shift engine itself is outside this block. It is reached through a start pulse, a busy level, a done pulse and the received byte.

The block watches for two faults. The first is a data write while a transfer is running (a write collision). The second is another master pulling the shared select input low while this port is driving the bus (a mode fault). A mode fault turns off the port's clock and data output drivers at once and sends the port back to slave. Completion and error flags stay set until software clears them with a fixed access sequence. An interrupt line reports completion and mode faults when interrupts are enabled.

Top module: `spi_supervisor`

## Requirements
- R1: After a synchronous reset, the configuration, select pattern, receive byte and all flags read back 0. `sel_out_n` is all ones, and `irq`, `xfer_start` and both drive enables are 0.
- R2: Address 0 holds the configuration byte and reads back what was written. Bits [2:0] are the rate select, bit 3 is phase, bit 4 is polarity, bit 5 is master, bit 6 is port enable and bit 7 is interrupt enable. The `cfg_*` outputs follow these bits, and both drive enables equal port enable AND master.
- R3: Address 3 holds the slave-select pattern and reads back what was written.
- R4: A data write (address 2) while idle loads `xfer_txd`. If the port is an enabled master, `xfer_start` is high for exactly the one cycle after the write edge, and `sel_out_n` becomes the bitwise inverse of the select pattern.
- R5: A `xfer_done` pulse captures `xfer_rxd` into the receive byte (read at address 2), sets the done flag (status bit 7) and returns `sel_out_n` to all ones.
- R6: A data write while `xfer_busy` is high, or in the cycle of a start pulse, sets the collision flag (status bit 6). It neither starts a transfer nor changes `xfer_txd`.
- R7: The done and collision flags clear only when a status read that saw them set is followed by a read or write at address 2. A data access without that earlier status read leaves them set.
- R8: While the port is an enabled master, a low `sel_in_n` sets the mode-fault flag (status bit 5) and clears the master and enable bits. The drive enables then fall and `sel_out_n` goes to all ones.
- R9: The mode-fault flag clears only when a status read that saw it set is followed by a configuration write. A configuration write without that earlier read leaves it set.
- R10: `irq` equals interrupt enable AND (done flag OR mode-fault flag). A collision alone does not raise it.
- R11: In slave mode, a data write loads `xfer_txd` without a start pulse or select activity, and a low `sel_in_n` raises no mode fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not reading) |
| sel_in_n | input | 1 | Shared select input, active low |
| sel_out_n | output | NUM_SEL | Slave-select outputs, active low |
| sck_drive_en | output | 1 | Serial clock output enable |
| mosi_drive_en | output | 1 | Master data output enable |
| cfg_master | output | 1 | Master mode to the shift engine |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_rate | output | 3 | Rate select |
| xfer_start | output | 1 | One-cycle transfer launch |
| xfer_txd | output | 8 | Transmit byte |
| xfer_busy | input | 1 | Shift engine busy |
| xfer_done | input | 1 | Shift engine finished a byte |
| xfer_rxd | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
Most state errors in this block reach the pins within one cycle. A flag that is set but should not be shows on the next status read and, for done or mode fault, on `irq` at once. A wrong clear-sequence arm stays hidden until the following data or configuration access, so the bench reads status both before and after every clearing access. A select or launch error appears on `sel_out_n` and `xfer_start` in the cycle after the data-write edge. A mode-fault error appears on the drive enables in the cycle after `sel_in_n` drops.

// File: rtl/spi_sup_pkg.sv
package spi_sup_pkg;

    localparam int BUS_W  = 8;
    localparam int RATE_W = 3;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_SEL  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              irq_en;
        logic              port_en;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } cfg_t;

    typedef struct packed {
        logic done;
        logic wcol;
        logic modf;
    } flags_t;

    function automatic logic [BUS_W-1:0] status_byte(flags_t f);
        return {f.done, f.wcol, f.modf, {(BUS_W-3){1'b0}}};
    endfunction

    function automatic logic owns_bus(cfg_t c);
        return c.port_en & c.master;
    endfunction

endpackage

// File: rtl/spi_sup_regs.sv
module spi_sup_regs
    import spi_sup_pkg::*;
#(
    parameter int NUM_SEL = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               sel_wr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               sel_in_n,
    output cfg_t               cfg_q,
    output logic [NUM_SEL-1:0] pattern_q,
    output logic               modf_evt
);

    assign modf_evt = owns_bus(cfg_q) & ~sel_in_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            pattern_q <= '0;
        end else begin
            if (cfg_wr)
                cfg_q <= cfg_t'(wdata);
            if (modf_evt) begin
                cfg_q.master  <= 1'b0;
                cfg_q.port_en <= 1'b0;
            end
            if (sel_wr)
                pattern_q <= wdata[NUM_SEL-1:0];
        end
    end

    AST_MODF_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
        modf_evt |=> (!cfg_q.master && !cfg_q.port_en)); // R8

endmodule

// File: rtl/spi_sup_flags.sv
module spi_sup_flags
    import spi_sup_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stat_rd,
    input  logic   data_acc,
    input  logic   cfg_wr,
    input  logic   done_evt,
    input  logic   wcol_evt,
    input  logic   modf_evt,
    output flags_t flags_q
);

    logic arm_done, arm_wcol, arm_modf;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            arm_done <= 1'b0;
            arm_wcol <= 1'b0;
            arm_modf <= 1'b0;
        end else begin
            if (stat_rd) begin
                arm_done <= flags_q.done;
                arm_wcol <= flags_q.wcol;
                arm_modf <= flags_q.modf;
            end else begin
                if (data_acc) begin
                    arm_done <= 1'b0;
                    arm_wcol <= 1'b0;
                end
                if (cfg_wr)
                    arm_modf <= 1'b0;
            end
            flags_q.done <= done_evt | (flags_q.done & ~(data_acc & arm_done));
            flags_q.wcol <= wcol_evt | (flags_q.wcol & ~(data_acc & arm_wcol));
            flags_q.modf <= modf_evt | (flags_q.modf & ~(cfg_wr & arm_modf));
        end
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> flags_q.done); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flags_q.done && !data_acc) |=> flags_q.done); // R7
    AST_MODF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flags_q.modf && !cfg_wr) |=> flags_q.modf); // R9

endmodule

// File: rtl/spi_sup_launch.sv
module spi_sup_launch
    import spi_sup_pkg::*;
#(
    parameter int NUM_SEL = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               data_wr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               busy,
    input  logic               active,
    input  logic               abort,
    input  logic               done,
    input  logic [NUM_SEL-1:0] pattern,
    output logic               start_q,
    output logic [BUS_W-1:0]   txd_q,
    output logic [NUM_SEL-1:0] sel_q,
    output logic               wcol_evt
);

    logic busy_eff, load, launch_now;

    assign busy_eff   = busy | start_q;
    assign wcol_evt   = data_wr & busy_eff;
    assign load       = data_wr & ~busy_eff;
    assign launch_now = load & active & ~abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            txd_q   <= '0;
            sel_q   <= '1;
        end else begin
            start_q <= launch_now;
            if (load)
                txd_q <= wdata;
            if (launch_now)
                sel_q <= ~pattern;
            else if (done || abort || !active)
                sel_q <= '1;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q); // R4
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        wcol_evt |=> (!start_q && $stable(txd_q))); // R6
    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (done && !launch_now) |=> (sel_q == '1)); // R5

endmodule

// File: rtl/spi_supervisor.sv
module spi_supervisor
    import spi_sup_pkg::*;
#(
    parameter int NUM_SEL = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_cs,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               sel_in_n,
    output logic [NUM_SEL-1:0] sel_out_n,
    output logic               sck_drive_en,
    output logic               mosi_drive_en,
    output logic               cfg_master,
    output logic               cfg_cpol,
    output logic               cfg_cpha,
    output logic [2:0]         cfg_rate,
    output logic               xfer_start,
    output logic [7:0]         xfer_txd,
    input  logic               xfer_busy,
    input  logic               xfer_done,
    input  logic [7:0]         xfer_rxd,
    output logic               irq
);

    reg_addr_e          addr;
    logic               wr_en, rd_en;
    logic               cfg_wr, sel_wr, data_wr, stat_rd, data_acc;
    cfg_t               cfg_q;
    logic [NUM_SEL-1:0] pattern_q;
    logic               modf_evt, wcol_evt;
    flags_t             flags_q;
    logic [BUS_W-1:0]   rx_q;
    logic [BUS_W-1:0]   pattern_rd;

    assign addr     = reg_addr_e'(bus_addr);
    assign wr_en    = bus_cs & bus_wr;
    assign rd_en    = bus_cs & bus_rd;
    assign cfg_wr   = wr_en && addr == A_CFG;
    assign sel_wr   = wr_en && addr == A_SEL;
    assign data_wr  = wr_en && addr == A_DATA;
    assign stat_rd  = rd_en && addr == A_STAT;
    assign data_acc = (wr_en | rd_en) && addr == A_DATA;

    spi_sup_regs #(.NUM_SEL(NUM_SEL)) regs_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .sel_wr(sel_wr),
        .wdata(bus_wdata), .sel_in_n(sel_in_n), .cfg_q(cfg_q),
        .pattern_q(pattern_q), .modf_evt(modf_evt)
    );

    spi_sup_flags flags_i (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_acc(data_acc),
        .cfg_wr(cfg_wr), .done_evt(xfer_done), .wcol_evt(wcol_evt),
        .modf_evt(modf_evt), .flags_q(flags_q)
    );

    spi_sup_launch #(.NUM_SEL(NUM_SEL)) launch_i (
        .clk(clk), .rst(rst), .data_wr(data_wr), .wdata(bus_wdata),
        .busy(xfer_busy), .active(owns_bus(cfg_q)), .abort(modf_evt),
        .done(xfer_done), .pattern(pattern_q), .start_q(xfer_start),
        .txd_q(xfer_txd), .sel_q(sel_out_n), .wcol_evt(wcol_evt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rx_q <= '0;
        else if (xfer_done)
            rx_q <= xfer_rxd;
    end

    always_comb begin
        pattern_rd                = '0;
        pattern_rd[NUM_SEL-1:0]   = pattern_q;
        bus_rdata                 = '0;
        if (rd_en) begin
            case (addr)
                A_CFG:   bus_rdata = cfg_q;
                A_STAT:  bus_rdata = status_byte(flags_q);
                A_DATA:  bus_rdata = rx_q;
                default: bus_rdata = pattern_rd;
            endcase
        end
    end

    assign sck_drive_en  = owns_bus(cfg_q);
    assign mosi_drive_en = owns_bus(cfg_q);
    assign cfg_master    = cfg_q.master;
    assign cfg_cpol      = cfg_q.cpol;
    assign cfg_cpha      = cfg_q.cpha;
    assign cfg_rate      = cfg_q.rate;
    assign irq           = cfg_q.irq_en & (flags_q.done | flags_q.modf);

    AST_IRQ_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (modf_evt && cfg_q.irq_en && !cfg_wr) |=> irq); // R10
    AST_SLAVE_NO_START: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.master |=> !xfer_start); // R11

endmodule

// File: tb/spi_supervisor_tb_top.sv
module spi_supervisor_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 0, bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       sel_in_n = 1;
    logic [7:0] sel_out_n;
    logic       sck_drive_en, mosi_drive_en, cfg_master, cfg_cpol, cfg_cpha;
    logic [2:0] cfg_rate;
    logic       xfer_start;
    logic [7:0] xfer_txd;
    logic       xfer_busy = 0, xfer_done = 0;
    logic [7:0] xfer_rxd = 0;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_supervisor dut_i (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sel_in_n(sel_in_n), .sel_out_n(sel_out_n), .sck_drive_en(sck_drive_en),
        .mosi_drive_en(mosi_drive_en), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .xfer_start(xfer_start),
        .xfer_txd(xfer_txd), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .xfer_rxd(xfer_rxd), .irq(irq)
    );

    // op[19:18] 1=write 2=read, addr[17:16], data[15:8], expected read[7:0]
    localparam logic [19:0] VEC [10] = '{
        {2'd1, 2'd0, 8'h1D, 8'h00},
        {2'd2, 2'd0, 8'h00, 8'h1D},
        {2'd1, 2'd3, 8'hA5, 8'h00},
        {2'd2, 2'd3, 8'h00, 8'hA5},
        {2'd2, 2'd1, 8'h00, 8'h00},
        {2'd1, 2'd0, 8'h00, 8'h00},
        {2'd2, 2'd0, 8'h00, 8'h00},
        {2'd1, 2'd3, 8'hFE, 8'h00},
        {2'd2, 2'd3, 8'h00, 8'hFE},
        {2'd2, 2'd2, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic engine_done(input logic [7:0] d);
        @(negedge clk);
        xfer_done = 1; xfer_busy = 0; xfer_rxd = d;
        @(negedge clk);
        xfer_done = 0;
    endtask

    task automatic pulse_sel_in;
        @(negedge clk);
        sel_in_n = 0;
        @(negedge clk);
        sel_in_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 sel", sel_out_n, 8'hFF);
        check("R1 irq", irq, 0);
        check("R1 start", xfer_start, 0);
        check("R1 drive", {sck_drive_en, mosi_drive_en}, 0);
        bus_read(0, rd); check("R1 cfg", rd, 0);
        bus_read(1, rd); check("R1 status", rd, 0);

        // R2 R3 table walk
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][19:18] == 2'd1)
                bus_write(VEC[i][17:16], VEC[i][15:8]);
            else begin
                bus_read(VEC[i][17:16], rd);
                check("R2/R3 table", rd, VEC[i][7:0]);
            end
        end

        // R2 config outputs
        bus_write(0, 8'h1D);
        check("R2 cfg outs", {cfg_master, cfg_cpol, cfg_cpha, cfg_rate}, {3'b011, 3'd5});
        check("R2 drive slave", sck_drive_en, 0);
        bus_write(0, 8'hE3);
        check("R2 drive master", {sck_drive_en, mosi_drive_en, cfg_master, cfg_rate}, {3'b111, 3'd3});

        // R4 launch
        bus_write(2, 8'h3C);
        check("R4 start", xfer_start, 1);
        check("R4 txd", xfer_txd, 8'h3C);
        check("R4 sel", sel_out_n, 8'h01);
        @(negedge clk);
        check("R4 one cycle", xfer_start, 0);
        xfer_busy = 1;

        // R6 collision
        bus_write(2, 8'h99);
        check("R6 no start", xfer_start, 0);
        check("R6 txd kept", xfer_txd, 8'h3C);
        bus_read(1, rd); check("R6 wcol flag", rd, 8'h40);
        check("R10 wcol no irq", irq, 0);

        // R5 completion
        engine_done(8'h6A);
        check("R5 sel release", sel_out_n, 8'hFF);
        check("R10 irq done", irq, 1);
        bus_read(1, rd); check("R5 status", rd, 8'hC0);
        bus_read(2, rd); check("R5 rx", rd, 8'h6A);
        bus_read(1, rd); check("R7 cleared", rd, 8'h00);
        check("R7 irq low", irq, 0);

        // R7 data access without status read keeps flag
        bus_write(2, 8'h11);
        check("R4 second start", xfer_start, 1);
        xfer_busy = 1;
        engine_done(8'h22);
        bus_read(2, rd); check("R5 rx2", rd, 8'h22);
        bus_read(1, rd); check("R7 kept", rd, 8'h80);
        bus_read(2, rd);
        bus_read(1, rd); check("R7 clear2", rd, 8'h00);

        // R8 mode fault
        pulse_sel_in();
        check("R8 drive off", {sck_drive_en, mosi_drive_en}, 0);
        check("R8 sel", sel_out_n, 8'hFF);
        check("R10 irq modf", irq, 1);
        bus_read(0, rd); check("R8 cfg", rd, 8'h83);
        // R9 write without status read keeps fault
        bus_write(0, 8'hE3);
        bus_read(1, rd); check("R9 kept", rd, 8'h20);
        check("R9 drive back", sck_drive_en, 1);
        bus_write(0, 8'h83);
        bus_read(1, rd); check("R9 cleared", rd, 8'h00);
        check("R9 irq low", irq, 0);

        // R11 slave
        bus_write(0, 8'h40);
        pulse_sel_in();
        bus_read(1, rd); check("R11 no modf", rd, 8'h00);
        bus_write(2, 8'h77);
        check("R11 no start", xfer_start, 0);
        check("R11 txd", xfer_txd, 8'h77);
        check("R11 sel", sel_out_n, 8'hFF);

        // R10 mask
        engine_done(8'h55);
        check("R10 masked", irq, 0);
        bus_read(1, rd); check("R5 slave done", rd, 8'h80);
        bus_write(0, 8'hC0);
        check("R10 unmasked", irq, 1);
        bus_read(2, rd); check("R5 rx3", rd, 8'h55);
        check("R7 irq after clear", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule